// File: doc/BRIEF.md
# Hierarchical Route and Broadcast Decoder

This block sits beside a router's arbiter and decides where a message goes. It does not arbitrate and it does not move data. A message's destination address is seven bits wide and splits into two parts. The upper five bits name a communicator: a host flag, a two-bit chip field and a two-bit fabric field. The lowest two bits give a rank inside that communicator. For a unicast message the block returns one output port index. For a broadcast it returns a mask of output ports.

A static type input and an own-communicator input set how the router behaves. A router of the local type delivers messages for its own communicator by rank, using a small rank table. It sends every other message out of the last port, which leads to the rest of the network. Routers of the fabric, inter-chip and host types look only at the communicator and use a communicator table.

A broadcast leaves through the ports that a programmable branch mask marks as spanning-tree branches. The port the broadcast arrived on is always removed from that set. All three tables are loaded through a single synchronous write port.

A request is sampled on a clock edge and its result appears on the outputs after that edge. Looking up a table entry that was never programmed raises an error flag in place of a permit.

Top module: `hier_route_decoder`

## Requirements
- R1: The address splits as follows. Bit 6 is the host flag, bits 5:4 are the chip field, bits 3:2 are the fabric field and bits 1:0 are the local field. The communicator is bits 6:2 and the rank is bits 1:0.
- R2: The result of a request sampled at a clock edge appears at that edge. Exactly one of rsp_permit_o and rsp_err_o is high for that cycle. With no request, both are low and rsp_port_o and rsp_mask_o are zero. This also holds during reset.
- R3: A local router (kind 0) that gets a unicast whose communicator equals own_comm_i takes the port from the rank table entry for the rank.
- R4: A local router that gets a unicast for any other communicator sends it to port NPORTS-1 (port 4). No table is involved.
- R5: The fabric, inter-chip and host kinds (1, 2 and 3) take the port from the communicator table entry for the communicator. The rank has no effect.
- R6: A unicast that needs an unprogrammed entry gives rsp_err_o=1 with rsp_permit_o=0, and the port and mask are zero.
- R7: A broadcast gives rsp_permit_o=1, rsp_bcast_o=1 and rsp_port_o=0. Its rsp_mask_o is the branch mask with the bit of req_src_i cleared. A broadcast never gives an error.
- R8: Writes are selected by tbl_wr_sel_i:
  - 0 writes communicator entry tbl_wr_idx_i.
  - 1 writes rank entry tbl_wr_idx_i, and only when tbl_wr_idx_i is below 4.
  - 2 loads the branch mask from tbl_wr_data_i[4:0].
  - 3 writes nothing.

  For an entry write, tbl_wr_data_i[2:0] is the port. A value of 5 or more returns the entry to the unprogrammed state. Reset clears every entry and the mask.
- R9: A lookup in the same cycle as a write to the entry it reads sees the contents from before the write.
- R10: For a permitted unicast, rsp_mask_o is the one-hot code of rsp_port_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| kind_i | input | 2 | Router type: 0 local, 1 fabric, 2 inter-chip, 3 host |
| own_comm_i | input | 5 | This router's own communicator |
| tbl_wr_en_i | input | 1 | Table write strobe |
| tbl_wr_sel_i | input | 2 | Write target select |
| tbl_wr_idx_i | input | 5 | Entry index |
| tbl_wr_data_i | input | 5 | Port code, or the branch mask |
| req_valid_i | input | 1 | Lookup request |
| req_bcast_i | input | 1 | The request is a broadcast |
| req_addr_i | input | 7 | Destination address |
| req_src_i | input | 3 | Input port the message arrived on |
| rsp_permit_o | output | 1 | Permit request for the result |
| rsp_err_o | output | 1 | Lookup hit an unprogrammed entry |
| rsp_bcast_o | output | 1 | The result is a broadcast mask |
| rsp_port_o | output | 3 | Unicast output port |
| rsp_mask_o | output | 5 | Output port mask |

## Verification
The table write port and a lookup can act in the same cycle, including on the very entry being looked up. The bench provokes this in two ways. A directed case rewrites a communicator entry and looks it up on the same edge. Random traffic mixes writes into about a quarter of the lookup cycles. The bench's own shadow tables produce each expected result from the contents before the write and then apply the write. A design that forwards the new value is therefore caught by a mismatch on that cycle, and a design that drops the write is caught by a mismatch on the cycle after.

// File: rtl/rt_pkg.sv
package rt_pkg;

  typedef enum logic [1:0] {
    KIND_LOCAL  = 2'd0,
    KIND_FABRIC = 2'd1,
    KIND_XCHIP  = 2'd2,
    KIND_HOST   = 2'd3
  } rt_kind_e;

  typedef enum logic [1:0] {
    TSEL_COMM  = 2'd0,
    TSEL_RANK  = 2'd1,
    TSEL_BCAST = 2'd2,
    TSEL_NONE  = 2'd3
  } rt_tsel_e;

endpackage

// File: rtl/rt_rst_sync.sv
module rt_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/rt_table.sv
module rt_table #(
  parameter int DEPTH  = 32,
  parameter int NPORTS = 5,
  parameter int PORT_W = 3,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [PORT_W-1:0] wr_port,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_hit,
  output logic [PORT_W-1:0] rd_port
);
  logic [DEPTH-1:0]  vld_all;
  logic [PORT_W-1:0] port_all [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic              ent_we;
    logic              vld_q, vld_d;
    logic [PORT_W-1:0] port_q, port_d;

    always_comb begin
      ent_we = wr_en && (wr_idx == IDX_W'(i));
      vld_d  = (wr_port < PORT_W'(NPORTS));
      port_d = wr_port;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q  <= 1'b0;
        port_q <= '0;
      end else if (ent_we) begin
        vld_q  <= vld_d;
        port_q <= port_d;
      end
    end

    assign vld_all[i]  = vld_q;
    assign port_all[i] = port_q;
  end

  assign rd_hit  = vld_all[rd_idx];
  assign rd_port = port_all[rd_idx];

  // R8: a written entry is valid exactly when the port code was in range
  assert_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (vld_all[$past(wr_idx)] == ($past(wr_port) < PORT_W'(NPORTS))));

endmodule

// File: rtl/rt_bcast_mask.sv
module rt_bcast_mask #(
  parameter int NPORTS = 5,
  parameter int PORT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [NPORTS-1:0] wr_mask,
  input  logic [PORT_W-1:0] src_port,
  output logic [NPORTS-1:0] fan_out
);
  logic [NPORTS-1:0] mask_q, mask_d, src_bit;

  always_comb mask_d = wr_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mask_q <= '0;
    else if (wr_en) mask_q <= mask_d;
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_src
    assign src_bit[p] = (src_port == PORT_W'(p));
  end

  assign fan_out = mask_q & ~src_bit;

  // R8: the branch mask holds the last value loaded
  assert_mask_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mask_q == $past(wr_mask)));

endmodule

// File: rtl/rt_route_sel.sv
module rt_route_sel #(
  parameter int NPORTS = 5,
  parameter int PORT_W = 3,
  parameter int COMM_W = 5
) (
  input  logic [1:0]        kind,
  input  logic [COMM_W-1:0] own_comm,
  input  logic [COMM_W-1:0] comm,
  input  logic              bcast,
  input  logic              comm_hit,
  input  logic [PORT_W-1:0] comm_port,
  input  logic              rank_hit,
  input  logic [PORT_W-1:0] rank_port,
  input  logic [NPORTS-1:0] fan_out,
  output logic              permit,
  output logic              err,
  output logic [PORT_W-1:0] port,
  output logic [NPORTS-1:0] mask
);
  import rt_pkg::*;

  logic              hit;
  logic [PORT_W-1:0] sel_port;

  always_comb begin
    if (rt_kind_e'(kind) == KIND_LOCAL) begin
      if (comm == own_comm) begin
        hit      = rank_hit;
        sel_port = rank_port;
      end else begin
        hit      = 1'b1;
        sel_port = PORT_W'(NPORTS - 1);
      end
    end else begin
      hit      = comm_hit;
      sel_port = comm_port;
    end
  end

  always_comb begin
    if (bcast) begin
      permit = 1'b1;
      err    = 1'b0;
      port   = '0;
      mask   = fan_out;
    end else begin
      permit = hit;
      err    = !hit;
      port   = hit ? sel_port : '0;
      for (int p = 0; p < NPORTS; p++) begin
        mask[p] = hit && (sel_port == PORT_W'(p));
      end
    end
  end

endmodule

// File: rtl/hier_route_decoder.sv
module hier_route_decoder #(
  parameter int NPORTS = 5,
  parameter int CHIP_W = 2,
  parameter int FAB_W  = 2,
  parameter int LOC_W  = 2,
  localparam int PORT_W = $clog2(NPORTS),
  localparam int COMM_W = 1 + CHIP_W + FAB_W,
  localparam int ADDR_W = COMM_W + LOC_W,
  localparam int DATA_W = (NPORTS > PORT_W) ? NPORTS : PORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        kind_i,
  input  logic [COMM_W-1:0] own_comm_i,
  input  logic              tbl_wr_en_i,
  input  logic [1:0]        tbl_wr_sel_i,
  input  logic [COMM_W-1:0] tbl_wr_idx_i,
  input  logic [DATA_W-1:0] tbl_wr_data_i,
  input  logic              req_valid_i,
  input  logic              req_bcast_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [PORT_W-1:0] req_src_i,
  output logic              rsp_permit_o,
  output logic              rsp_err_o,
  output logic              rsp_bcast_o,
  output logic [PORT_W-1:0] rsp_port_o,
  output logic [NPORTS-1:0] rsp_mask_o
);
  import rt_pkg::*;

  logic srst_n;
  rt_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  // address fields
  logic [COMM_W-1:0] req_comm;
  logic [LOC_W-1:0]  req_rank;
  assign req_comm = req_addr_i[ADDR_W-1:LOC_W];
  assign req_rank = req_addr_i[LOC_W-1:0];

  // write decode
  logic we_comm, we_rank, we_bcast;
  assign we_comm  = tbl_wr_en_i && (rt_tsel_e'(tbl_wr_sel_i) == TSEL_COMM);
  assign we_rank  = tbl_wr_en_i && (rt_tsel_e'(tbl_wr_sel_i) == TSEL_RANK)
                    && (tbl_wr_idx_i[COMM_W-1:LOC_W] == '0);
  assign we_bcast = tbl_wr_en_i && (rt_tsel_e'(tbl_wr_sel_i) == TSEL_BCAST);

  logic              comm_hit, rank_hit;
  logic [PORT_W-1:0] comm_port, rank_port;
  logic [NPORTS-1:0] fan_out;

  rt_table #(.DEPTH(1 << COMM_W), .NPORTS(NPORTS), .PORT_W(PORT_W)) u_comm_tbl (
    .clk(clk), .rst_n(srst_n),
    .wr_en(we_comm), .wr_idx(tbl_wr_idx_i), .wr_port(tbl_wr_data_i[PORT_W-1:0]),
    .rd_idx(req_comm), .rd_hit(comm_hit), .rd_port(comm_port)
  );

  rt_table #(.DEPTH(1 << LOC_W), .NPORTS(NPORTS), .PORT_W(PORT_W)) u_rank_tbl (
    .clk(clk), .rst_n(srst_n),
    .wr_en(we_rank), .wr_idx(tbl_wr_idx_i[LOC_W-1:0]), .wr_port(tbl_wr_data_i[PORT_W-1:0]),
    .rd_idx(req_rank), .rd_hit(rank_hit), .rd_port(rank_port)
  );

  rt_bcast_mask #(.NPORTS(NPORTS), .PORT_W(PORT_W)) u_bmask (
    .clk(clk), .rst_n(srst_n),
    .wr_en(we_bcast), .wr_mask(tbl_wr_data_i[NPORTS-1:0]),
    .src_port(req_src_i), .fan_out(fan_out)
  );

  logic              sel_permit, sel_err;
  logic [PORT_W-1:0] sel_port;
  logic [NPORTS-1:0] sel_mask;

  rt_route_sel #(.NPORTS(NPORTS), .PORT_W(PORT_W), .COMM_W(COMM_W)) u_sel (
    .kind(kind_i), .own_comm(own_comm_i), .comm(req_comm), .bcast(req_bcast_i),
    .comm_hit(comm_hit), .comm_port(comm_port),
    .rank_hit(rank_hit), .rank_port(rank_port),
    .fan_out(fan_out),
    .permit(sel_permit), .err(sel_err), .port(sel_port), .mask(sel_mask)
  );

  // result register: next state
  logic              permit_d, err_d, bcast_d;
  logic [PORT_W-1:0] port_d;
  logic [NPORTS-1:0] mask_d;

  always_comb begin
    permit_d = req_valid_i && sel_permit;
    err_d    = req_valid_i && sel_err;
    bcast_d  = req_valid_i && req_bcast_i;
    port_d   = req_valid_i ? sel_port : '0;
    mask_d   = req_valid_i ? sel_mask : '0;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rsp_permit_o <= 1'b0;
      rsp_err_o    <= 1'b0;
      rsp_bcast_o  <= 1'b0;
      rsp_port_o   <= '0;
      rsp_mask_o   <= '0;
    end else begin
      rsp_permit_o <= permit_d;
      rsp_err_o    <= err_d;
      rsp_bcast_o  <= bcast_d;
      rsp_port_o   <= port_d;
      rsp_mask_o   <= mask_d;
    end
  end

  // R2: a request yields exactly one outcome, idle yields none
  assert_one_outcome_R2: assert property (@(posedge clk) disable iff (!srst_n)
    req_valid_i |=> (rsp_permit_o ^ rsp_err_o));
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!srst_n)
    !req_valid_i |=> (!rsp_permit_o && !rsp_err_o && rsp_mask_o == '0));

  // R4: foreign communicator on a local router leaves by the last port
  assert_foreign_last_R4: assert property (@(posedge clk) disable iff (!srst_n)
    (req_valid_i && !req_bcast_i && rt_kind_e'(kind_i) == KIND_LOCAL && req_comm != own_comm_i)
    |=> (rsp_permit_o && rsp_port_o == PORT_W'(NPORTS - 1)));

  // R6: an error carries no port selection
  assert_err_empty_R6: assert property (@(posedge clk) disable iff (!srst_n)
    rsp_err_o |-> (!rsp_permit_o && rsp_mask_o == '0 && rsp_port_o == '0));

  // R7: a broadcast is never reflected to its source
  assert_no_reflect_R7: assert property (@(posedge clk) disable iff (!srst_n)
    (req_valid_i && req_bcast_i && req_src_i < PORT_W'(NPORTS))
    |=> (rsp_permit_o && !rsp_mask_o[$past(req_src_i)]));

  // R10: a permitted unicast drives a single port bit
  assert_unicast_onehot_R10: assert property (@(posedge clk) disable iff (!srst_n)
    (rsp_permit_o && !rsp_bcast_o) |-> ($countones(rsp_mask_o) == 1));

endmodule

// File: tb/tb_hier_route_decoder.sv
module tb_hier_route_decoder;
  localparam int NP = 5;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] kind;
  logic [4:0] own;
  logic       wr_en;
  logic [1:0] wr_sel;
  logic [4:0] wr_idx;
  logic [4:0] wr_data;
  logic       rq_v, rq_b;
  logic [6:0] rq_a;
  logic [2:0] rq_s;
  logic       o_permit, o_err, o_bcast;
  logic [2:0] o_port;
  logic [4:0] o_mask;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  // shadow tables
  bit       sc_v [32];
  bit [2:0] sc_p [32];
  bit       sr_v [4];
  bit [2:0] sr_p [4];
  bit [4:0] sb;

  always #5 clk = ~clk;

  hier_route_decoder dut (
    .clk(clk), .rst_n(rst_n), .kind_i(kind), .own_comm_i(own),
    .tbl_wr_en_i(wr_en), .tbl_wr_sel_i(wr_sel), .tbl_wr_idx_i(wr_idx),
    .tbl_wr_data_i(wr_data), .req_valid_i(rq_v), .req_bcast_i(rq_b),
    .req_addr_i(rq_a), .req_src_i(rq_s),
    .rsp_permit_o(o_permit), .rsp_err_o(o_err), .rsp_bcast_o(o_bcast),
    .rsp_port_o(o_port), .rsp_mask_o(o_mask)
  );

  // result vector layout: {permit, err, bcast, port[2:0], mask[4:0]}
  task automatic check(input logic [10:0] exp, input string tag);
    logic [10:0] act;
    act = {o_permit, o_err, o_bcast, o_port, o_mask};
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic model(output logic [10:0] exp, output string tag);
    logic [4:0] comm;
    logic [1:0] rank;
    bit hit;
    logic [2:0] p;
    comm = rq_a[6:2];
    rank = rq_a[1:0];
    if (!rq_v) begin
      exp = '0; tag = "R2";
    end else if (rq_b) begin
      exp = {3'b101, 3'b000, sb & ~(5'b00001 << rq_s)}; tag = "R7";
    end else begin
      if (kind == 2'd0 && comm == own) begin
        hit = sr_v[rank]; p = sr_p[rank]; tag = hit ? "R3" : "R3/R6";
      end else if (kind == 2'd0) begin
        hit = 1'b1; p = 3'd4; tag = "R4";
      end else begin
        hit = sc_v[comm]; p = sc_p[comm]; tag = hit ? "R5" : "R6";
      end
      if (hit) exp = {3'b100, p, 5'b00001 << p};
      else     exp = {3'b010, 3'b000, 5'b00000};
    end
  endtask

  task automatic shadow_write();
    if (wr_en) begin
      case (wr_sel)
        2'd0: begin sc_v[wr_idx] = (wr_data[2:0] < 3'd5); sc_p[wr_idx] = wr_data[2:0]; end
        2'd1: if (wr_idx[4:2] == 3'b000) begin
                sr_v[wr_idx[1:0]] = (wr_data[2:0] < 3'd5); sr_p[wr_idx[1:0]] = wr_data[2:0];
              end
        2'd2: sb = wr_data;
        default: ;
      endcase
    end
  endtask

  task automatic step(input string tag_ovr);
    logic [10:0] exp;
    string tg;
    model(exp, tg);
    if (tag_ovr != "") tg = tag_ovr;
    shadow_write();
    @(posedge clk);
    @(negedge clk);
    check(exp, tg);
  endtask

  task automatic idle_in();
    wr_en = 0; wr_sel = 2'd3; wr_idx = 0; wr_data = 0;
    rq_v = 0; rq_b = 0; rq_a = 0; rq_s = 0;
  endtask

  task automatic write_only(input logic [1:0] s, input logic [4:0] i, input logic [4:0] d);
    idle_in();
    wr_en = 1; wr_sel = s; wr_idx = i; wr_data = d;
    step("R8");
  endtask

  task automatic lookup(input logic b, input logic [6:0] a, input logic [2:0] s, input string tg);
    idle_in();
    rq_v = 1; rq_b = b; rq_a = a; rq_s = s;
    step(tg);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL R2: watchdog expired, actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 32; i++) begin sc_v[i] = 0; sc_p[i] = 0; end
    for (int i = 0; i < 4; i++) begin sr_v[i] = 0; sr_p[i] = 0; end
    sb = 0;
    kind = 2'd1; own = 5'd0;
    idle_in();
    rst_n = 1'b0;
    rq_v = 1; rq_a = 7'h15;
    repeat (3) @(negedge clk);
    check('0, "R2 reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    idle_in();

    // R8 reset leaves tables empty: fabric lookup errors
    lookup(0, 7'h15, 3'd0, "R8 reset/R6");
    kind = 2'd2; lookup(1, 7'h00, 3'd1, "R8 reset/R7");

    // R1 field layout: comm = {host=1, chip=01, fabric=10}
    kind = 2'd1;
    write_only(2'd0, 5'b1_01_10, 5'd2);
    lookup(0, {5'b1_01_10, 2'b11}, 3'd0, "R1/R5");
    lookup(0, {5'b1_01_10, 2'b00}, 3'd3, "R1/R5");
    lookup(0, {5'b0_01_10, 2'b11}, 3'd0, "R1/R6");
    kind = 2'd3; lookup(0, {5'b1_01_10, 2'b01}, 3'd0, "R5 host");

    // R3 / R4 local router
    kind = 2'd0; own = 5'b1_01_10;
    write_only(2'd1, 5'd3, 5'd1);
    lookup(0, {5'b1_01_10, 2'b11}, 3'd0, "R1/R3");
    lookup(0, {5'b1_01_10, 2'b10}, 3'd0, "R3/R6");
    lookup(0, {5'b0_11_01, 2'b11}, 3'd2, "R4");
    write_only(2'd1, 5'd7, 5'd0);     // out-of-range rank index ignored
    lookup(0, {5'b1_01_10, 2'b11}, 3'd0, "R8 rank range");

    // R9 write and lookup on the same entry in one cycle
    kind = 2'd1;
    idle_in();
    wr_en = 1; wr_sel = 2'd0; wr_idx = 5'b1_01_10; wr_data = 5'd3;
    rq_v = 1; rq_a = {5'b1_01_10, 2'b00};
    step("R9 old");
    lookup(0, {5'b1_01_10, 2'b00}, 3'd0, "R9 new");

    // R8 clear with out-of-range port code
    write_only(2'd0, 5'b1_01_10, 5'd6);
    lookup(0, {5'b1_01_10, 2'b00}, 3'd0, "R8 clear/R6");

    // R7 broadcast masking, R10 one-hot
    write_only(2'd2, 5'd0, 5'b10110);
    lookup(1, 7'h7f, 3'd1, "R7 src1");
    lookup(1, 7'h00, 3'd0, "R7 src0");
    lookup(1, 7'h22, 3'd4, "R7 src4");
    write_only(2'd0, 5'd9, 5'd4);
    lookup(0, {5'd9, 2'b10}, 3'd0, "R10");

    // constrained random with writes mixed in
    for (int i = 0; i < 4000; i++) begin
      if (i % 250 == 0) begin
        kind = 2'($urandom_range(0, 3));
        own  = 5'($urandom);
      end
      idle_in();
      wr_en   = ($urandom_range(0, 3) == 0);
      wr_sel  = 2'($urandom_range(0, 3));
      wr_idx  = 5'($urandom);
      if (wr_sel == 2'd1 && $urandom_range(0, 1) == 1) wr_idx[4:2] = 3'b000;
      wr_data = 5'($urandom);
      rq_v    = ($urandom_range(0, 3) != 0);
      rq_b    = ($urandom_range(0, 4) == 0);
      rq_a    = 7'($urandom);
      if (kind == 2'd0 && $urandom_range(0, 1) == 1) rq_a[6:2] = own;
      rq_s    = 3'($urandom_range(0, 4));
      step("");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule